// File: doc/BRIEF.md
# Modem Line Status Tracker

This block watches four active-low modem handshake inputs (carrier detect, ring, data-set-ready and clear-to-send). It turns them into a read-only 32-bit status word for a simple bus slave port. The low byte of the word holds two halves. The upper nibble gives the present asserted state of each line. The lower nibble holds sticky change flags that collect activity between reads. A modem-status interrupt request is raised while any change flag is set and the interrupt enable input is high.

Each line pin is first passed through a multi-flop synchronizer. A loopback input can replace the pins with four internal control bits. Change detection always runs on whichever source is selected, so a toggle of a loopback control bit sets flags exactly as a pin transition would. Selecting or deselecting loopback is also seen as a change wherever the two sources differ.

A read strobe addressed to the register returns the word as it stands and clears the change flags at the following clock edge. An event that lands on that same edge is kept. Write strobes never alter the state.

Top module: `modem_status_unit`

## Requirements
- R1: After reset, a read of the register returns 0x00000000 and `irq` is 0.
- R2: Read data bits 31:8 are always zero, and `rd_data` is zero whenever no read to offset 0x18 is in progress.
- R3: With loopback off, bits 7, 6, 5 and 4 read as the inverse of `line_n[3]` (carrier), `line_n[2]` (ring), `line_n[1]` (data set ready) and `line_n[0]` (clear to send). A pin change made before clock edge 1 becomes visible after edge 3 (two synchronizer stages plus one status register).
- R4: With `loop_en` high, bits 7, 6, 5 and 4 follow `ctl_out2`, `ctl_out1`, `ctl_dtr` and `ctl_rts`, one edge after those bits change, and the pins have no effect.
- R5: Bit 3, bit 1 and bit 0 set when the carrier, data-set-ready or clear-to-send source changes in either direction.
- R6: Bit 2 sets only when the ring source stops being asserted (ring pin goes 0 to 1). It does not set when the ring becomes asserted.
- R7: A read (`bus_rd`=1, `bus_wr`=0, `bus_addr`=0x18) returns the pre-clear value combinationally and clears bits 3:0 at the next edge.
- R8: A change event landing on the same edge as a clearing read leaves its flag set.
- R9: A write strobe never clears or changes flags, including a cycle where `bus_wr` and `bus_rd` are both high, which counts as a write.
- R10: A read strobe to any address other than 0x18 does not clear the flags.
- R11: `irq` is 1 exactly when `irq_en` is 1 and at least one of bits 3:0 is 1.
- R12: In loopback, toggling a control bit sets the matching change flag under the rules of R5 and R6, and entering or leaving loopback counts as a change wherever the sources differ.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_n | input | 4 | Active-low pins: [3] carrier, [2] ring, [1] data set ready, [0] clear to send |
| loop_en | input | 1 | Loopback select |
| ctl_out2 | input | 1 | Loopback source for carrier |
| ctl_out1 | input | 1 | Loopback source for ring |
| ctl_dtr | input | 1 | Loopback source for data set ready |
| ctl_rts | input | 1 | Loopback source for clear to send |
| irq_en | input | 1 | Modem-status interrupt enable |
| bus_addr | input | ADDR_W | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe (ignored) |
| rd_data | output | DATA_W | Read data |
| irq | output | 1 | Modem-status interrupt request |

## Verification
The bench builds the block with its defaults: a two-stage synchronizer, an 8-bit address, the 0x18 offset and a 32-bit data word. With two stages the pin-to-status latency is exactly three edges, so the bench can read one cycle early and see nothing, then read again and see the change. That early read also lands on the capture edge, which puts the read-versus-event collision within reach through the pins as well as through loopback. The 32-bit word leaves 24 padding bits that every table read checks against zero.

// File: rtl/msr_pkg.sv
package msr_pkg;
    localparam int unsigned LINE_CNT = 4;
    localparam int unsigned IDX_CTS  = 0;
    localparam int unsigned IDX_DSR  = 1;
    localparam int unsigned IDX_RING = 2;
    localparam int unsigned IDX_DCD  = 3;

    typedef logic [LINE_CNT-1:0] line_vec_t;

    typedef struct packed {
        line_vec_t level;
        line_vec_t flags;
    } track_state_t;
endpackage

// File: rtl/msr_line_sync.sv
module msr_line_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned WIDTH  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d;
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    // pins are taken as idle-high while reset is held
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/msr_src_select.sv
module msr_src_select
    import msr_pkg::*;
(
    input  logic      loop_en,
    input  line_vec_t pin_sync_n,
    input  line_vec_t ctl_bits,
    output line_vec_t active
);
    always_comb begin
        if (loop_en) begin
            active = ctl_bits;
        end else begin
            active = ~pin_sync_n;
        end
    end
endmodule

// File: rtl/msr_event_detect.sv
module msr_event_detect
    import msr_pkg::*;
#(
    parameter int unsigned TRAIL_IDX = IDX_RING
) (
    input  line_vec_t prev,
    input  line_vec_t cur,
    output line_vec_t events
);
    for (genvar i = 0; i < LINE_CNT; i++) begin : g_line
        if (i == TRAIL_IDX) begin : g_trail
            // only the de-assertion of the line counts
            assign events[i] = prev[i] & ~cur[i];
        end else begin : g_any
            assign events[i] = prev[i] ^ cur[i];
        end
    end
endmodule

// File: rtl/modem_status_unit.sv
module modem_status_unit
    import msr_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned REG_OFFSET  = 'h18,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        line_n,
    input  logic              loop_en,
    input  logic              ctl_out2,
    input  logic              ctl_out1,
    input  logic              ctl_dtr,
    input  logic              ctl_rts,
    input  logic              irq_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    localparam int unsigned STATUS_W = 2 * LINE_CNT;
    localparam int unsigned PAD_W    = DATA_W - STATUS_W;
    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_OFFSET);

    line_vec_t    pin_sync_n;
    line_vec_t    ctl_bits;
    line_vec_t    active;
    line_vec_t    ev_now;
    line_vec_t    flags_q;
    line_vec_t    level_q;
    logic         rd_hit;
    track_state_t st_d;
    track_state_t st_q;

    msr_line_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (LINE_CNT)
    ) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (line_n),
        .sync_o  (pin_sync_n)
    );

    always_comb begin
        ctl_bits           = '0;
        ctl_bits[IDX_DCD]  = ctl_out2;
        ctl_bits[IDX_RING] = ctl_out1;
        ctl_bits[IDX_DSR]  = ctl_dtr;
        ctl_bits[IDX_CTS]  = ctl_rts;
    end

    msr_src_select i_sel (
        .loop_en    (loop_en),
        .pin_sync_n (pin_sync_n),
        .ctl_bits   (ctl_bits),
        .active     (active)
    );

    msr_event_detect #(
        .TRAIL_IDX (IDX_RING)
    ) i_evt (
        .prev   (st_q.level),
        .cur    (active),
        .events (ev_now)
    );

    // a cycle carrying a write strobe is a write, never a read
    assign rd_hit = bus_rd && !bus_wr && (bus_addr == HIT_ADDR);

    always_comb begin
        st_d       = st_q;
        st_d.level = active;
        st_d.flags = (rd_hit ? '0 : st_q.flags) | ev_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_q = st_q.flags;
    assign level_q = st_q.level;
    assign rd_data = rd_hit ? {{PAD_W{1'b0}}, st_q.level, st_q.flags} : '0;
    assign irq     = irq_en && (st_q.flags != '0);
endmodule

// File: rtl/msr_status_chk.sv
module msr_status_chk
    import msr_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      rd_hit,
    input logic      loop_en,
    input line_vec_t ctl_bits,
    input line_vec_t ev_now,
    input line_vec_t flags_q,
    input line_vec_t level_q
);
    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |=> (flags_q == $past(ev_now)));

    assert_only_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    assert_carrier_delta_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (level_q[IDX_DCD] != $past(level_q[IDX_DCD])) |-> flags_q[IDX_DCD]);

    assert_ring_lead_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(level_q[IDX_RING]) |-> !$rose(flags_q[IDX_RING]));

    assert_loop_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(loop_en)) |-> (level_q == $past(ctl_bits)));
endmodule

bind modem_status_unit msr_status_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_hit   (rd_hit),
    .loop_en  (loop_en),
    .ctl_bits (ctl_bits),
    .ev_now   (ev_now),
    .flags_q  (flags_q),
    .level_q  (level_q)
);

// File: tb/test_modem_status_unit.sv
`timescale 1ns/1ps
module test_modem_status_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  line_n = 4'b1111;
    logic        loop_en = 1'b0;
    logic [3:0]  ctl = 4'b0000;
    logic        irq_en = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] rd_data;
    logic        irq;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    modem_status_unit i_modem_status_unit (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_n   (line_n),
        .loop_en  (loop_en),
        .ctl_out2 (ctl[3]),
        .ctl_out1 (ctl[2]),
        .ctl_dtr  (ctl[1]),
        .ctl_rts  (ctl[0]),
        .irq_en   (irq_en),
        .bus_addr (bus_addr),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .rd_data  (rd_data),
        .irq      (irq)
    );

    typedef struct packed {
        logic [3:0] pins;
        logic       loop;
        logic [3:0] ctl;
        logic       ien;
        logic [7:0] exp_rd;
        logic       exp_irq;
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t TABLE [NVEC] = '{
        '{4'b1111, 1'b0, 4'b0000, 1'b1, 8'h00, 1'b0},
        '{4'b1110, 1'b0, 4'b0000, 1'b1, 8'h11, 1'b1},
        '{4'b1100, 1'b0, 4'b0000, 1'b1, 8'h32, 1'b1},
        '{4'b1000, 1'b0, 4'b0000, 1'b0, 8'h70, 1'b0},
        '{4'b0000, 1'b0, 4'b0000, 1'b1, 8'hF8, 1'b1},
        '{4'b1111, 1'b0, 4'b0000, 1'b1, 8'h0F, 1'b1},
        '{4'b1111, 1'b0, 4'b0000, 1'b0, 8'h00, 1'b0},
        '{4'b0000, 1'b1, 4'b0000, 1'b1, 8'h00, 1'b0},
        '{4'b0000, 1'b1, 4'b1010, 1'b1, 8'hAA, 1'b1},
        '{4'b0000, 1'b1, 4'b0110, 1'b1, 8'h68, 1'b1},
        '{4'b0000, 1'b1, 4'b0010, 1'b1, 8'h24, 1'b1},
        '{4'b0000, 1'b0, 4'b0000, 1'b1, 8'hF9, 1'b1},
        '{4'b1111, 1'b0, 4'b0000, 1'b1, 8'h0F, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_read(input logic [7:0] addr, input logic [7:0] exp, input string req);
        bus_addr = addr;
        bus_rd = 1'b1;
        #1;
        check(req, rd_data, {24'h0, exp});
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        settle(3);
        rst_n = 1'b1;
        check("R1 irq after reset", {31'h0, irq}, 32'h0);
        do_read(8'h18, 8'h00, "R1 reset read");

        // table walk: each entry settles three edges, then reads (and clears)
        for (int i = 0; i < NVEC; i++) begin
            line_n  = TABLE[i].pins;
            loop_en = TABLE[i].loop;
            ctl     = TABLE[i].ctl;
            irq_en  = TABLE[i].ien;
            settle(3);
            check($sformatf("R11 irq vec %0d", i), {31'h0, irq}, {31'h0, TABLE[i].exp_irq});
            do_read(8'h18, TABLE[i].exp_rd, $sformatf("R3 R4 R5 R6 R12 R2 vec %0d", i));
        end

        // R10: read elsewhere returns zero and does not clear
        line_n = 4'b1110;
        settle(3);
        do_read(8'h14, 8'h00, "R10 other address");
        do_read(8'h18, 8'h11, "R10 flag kept");

        // R9: write, then write+read together, leave the flag alone
        line_n = 4'b1111;
        settle(3);
        bus_addr = 8'h18;
        bus_wr = 1'b1;
        settle(1);
        bus_rd = 1'b1;
        #1;
        check("R9 rd_data zero during write", rd_data, 32'h0);
        settle(1);
        bus_rd = 1'b0;
        bus_wr = 1'b0;
        check("R11 irq on flag", {31'h0, irq}, 32'h1);
        do_read(8'h18, 8'h01, "R9 flag survives writes");
        do_read(8'h18, 8'h00, "R7 cleared after read");
        check("R7 irq after clear", {31'h0, irq}, 32'h0);

        // R8: loopback event on the edge of a clearing read
        loop_en = 1'b1;
        ctl = 4'b0000;
        settle(1);
        ctl = 4'b0001;
        do_read(8'h18, 8'h00, "R8 pre-clear value");
        do_read(8'h18, 8'h11, "R8 collided event kept");

        // R11: enable gating
        ctl = 4'b0000;
        irq_en = 1'b0;
        settle(1);
        check("R11 irq masked", {31'h0, irq}, 32'h0);
        irq_en = 1'b1;
        #1;
        check("R11 irq enabled", {31'h0, irq}, 32'h1);
        @(negedge clk);
        do_read(8'h18, 8'h01, "R12 loopback release flag");

        // R3: pin latency of three edges, read colliding on the capture edge
        loop_en = 1'b0;
        settle(1);
        line_n = 4'b0111;
        settle(2);
        do_read(8'h18, 8'h00, "R3 not yet visible");
        do_read(8'h18, 8'h88, "R3 visible after third edge");

        // R4: pins have no effect in loopback
        loop_en = 1'b1;
        ctl = 4'b0000;
        settle(1);
        do_read(8'h18, 8'h08, "R12 entering loopback");
        line_n = 4'b0000;
        settle(4);
        do_read(8'h18, 8'h00, "R4 pins ignored");
        line_n = 4'b1111;
        settle(4);
        do_read(8'h18, 8'h00, "R4 pins ignored again");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule